// File: doc/BRIEF.md
# Masked Result Writeback Router

This block commits one instruction's results to register storage. Each transaction carries a four-lane vector result, a single-lane scalar result and two 32-bit decoded control words (`ctl0`, `ctl3`). From these fields the router works out where each result goes and which lanes it may touch. The possible targets are a bank of 32 temporary registers, a bank of 16 output registers and a pair of condition registers. Every register holds four IEEE-754 single-precision lanes. Lane x is bits [31:0], y is [63:32], z is [95:64] and w is [127:96]. The block does not compute results. It only routes and masks them, with optional clamping to [0,1] on the way in.

Vector lanes can also be gated by a condition test. The test looks at the sign/zero state of a lane-permuted copy of one condition register. A reserved destination index of 63 sends a result to the output bank or to a condition register instead of a temporary.

Results arrive on a valid/ready stream. `in_ready` is held high at all times, because a write always completes in one cycle and there is no back-pressure. A transaction is taken on every rising clock edge where `in_valid` is high. The three banks each have a combinational read port, so a value written on an edge can be read immediately after that edge.

Top module: `cc_wb_router`

## Requirements
- R1: `in_ready` is always 1. Storage changes only on an edge with `in_valid` high; an edge with `in_valid` low leaves every register unchanged.
- R2: An active-low `rst_n` clears every lane of every temporary, output and condition register to 0x00000000.
- R3: Condition code `ctl0[12:10]` uses LT=1, EQ=2, GT=4. A lane passes when its condition value is negative and LT is set, is +0 or -0 and EQ is set, or is positive and GT is set. A NaN passes no flag. Code 7 passes every lane, NaN included. Code 0 passes none.
- R4: The condition register is chosen by `ctl0[25]`. The condition value for lane x is the source lane selected by `ctl0[9:8]`; y uses `ctl0[7:6]`, z uses `ctl0[5:4]` and w uses `ctl0[3:2]`. Selector 0..3 means x..w. Condition values are read before this cycle's writes land.
- R5: The vector lane mask is x=`ctl3[16]`, y=`ctl3[15]`, z=`ctl3[14]`, w=`ctl3[13]`. It is ANDed with the per-lane condition result only when `ctl0[13]` is 1.
- R6: When the vector temp index `ctl0[20:15]` is 63 and the result-select bit `ctl0[30]` is 0, the vector goes only to the selected condition register.
- R7: Otherwise the vector goes to output register `ctl3[6:2]` when `ctl0[30]` is 1 and that index is below 16. It also goes to temp register `ctl0[20:15]` when that index is below 32. Temp indices 32..62 and output indices 16..31 write nothing.
- R8: The scalar is copied to all four lanes and uses mask x=`ctl3[20]`, y=`ctl3[19]`, z=`ctl3[18]`, w=`ctl3[17]`. Its temp index is `ctl3[12:7]`, and an index of 32..62 writes nothing. Index 63 sends it to output register `ctl3[6:2]` (below 16 only) when `ctl0[30]` is 0, or to the selected condition register when `ctl0[30]` is 1. The condition test does not gate the scalar.
- R9: With `ctl0[26]` set, each written lane is clamped on its bit pattern. Any sign-bit-set value, -0 included, becomes 0. Any NaN becomes 0. Any value at or above 1.0 (+inf included) becomes 0x3F800000. Values in between are unchanged.
- R10: When the vector and scalar paths write the same lane of the same register in one transaction, the scalar value is stored.
- R11: `tmp_rdata`, `out_rdata` and `cc_rdata` show the addressed register combinationally, including a write from the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction present |
| in_ready | output | 1 | Always high; router never stalls |
| ctl0 | input | 32 | Decoded control word 0 (routing, condition, saturate) |
| ctl3 | input | 32 | Decoded control word 3 (masks, output and scalar indices) |
| vec_data | input | 128 | Vector result, four lanes |
| sca_data | input | 32 | Scalar result |
| tmp_raddr | input | 5 | Temporary register read index |
| tmp_rdata | output | 128 | Temporary register read data |
| out_raddr | input | 4 | Output register read index |
| out_rdata | output | 128 | Output register read data |
| cc_raddr | input | 1 | Condition register read index |
| cc_rdata | output | 128 | Condition register read data |

## Verification
The condition test is first run against one condition register loaded with -1, 0, +1 and NaN, using every code. This shows whether each flag picks the correct sign class, and how NaN is treated under code 7 versus the other codes. The same register is then read through a reversed permutation, and separately the other condition register is selected. These two cases tell a swizzle error apart from a register-select error. Routing is covered by directed cases for each destination class, the reserved 63 index under both settings of the result-select bit, and out-of-range indices that must write nothing. The final phase drives random control words and lane values drawn from a pool of signed zeros, ones, NaN and infinity. It compares all 50 registers through the read ports after every clock, which exposes ordering, priority and clamping faults that the directed cases would not combine.

// File: rtl/cc_wb_pkg.sv
`timescale 1ns/1ps
package cc_wb_pkg;
  localparam int LANE_W = 32;
  localparam int LANES  = 4;
  localparam int NCC    = 2;
  localparam logic [5:0] IDX_RESERVED = 6'd63;
  localparam logic [31:0] FP_ONE = 32'h3F80_0000;

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic       v_cc;
    logic       v_out;
    logic       v_tmp;
    logic [5:0] v_tmp_idx;
    logic       s_cc;
    logic       s_out;
    logic       s_tmp;
    logic [5:0] s_tmp_idx;
    logic [4:0] out_idx;
    logic       cc_sel;
    logic       sat;
    logic       cond_en;
    logic [2:0] code;
    logic [7:0] swz;
    logic [3:0] vmask;
    logic [3:0] smask;
  } route_t;

  // Returns {positive, zero, negative}; NaN sets none.
  function automatic logic [2:0] fp_class(lane_t v);
    logic nan, zero;
    nan  = (v[30:23] == 8'hFF) && (v[22:0] != '0);
    zero = (v[30:0] == '0);
    return {!nan && !zero && !v[31], zero, !nan && !zero && v[31]};
  endfunction

  function automatic lane_t sat_lane(lane_t v);
    logic nan;
    nan = (v[30:23] == 8'hFF) && (v[22:0] != '0);
    if (nan || v[31])          return '0;
    else if (v >= FP_ONE)      return FP_ONE;
    else                       return v;
  endfunction
endpackage

// File: rtl/cc_route_dec.sv
`timescale 1ns/1ps
module cc_route_dec
  import cc_wb_pkg::*;
(
  input  logic [31:0] ctl0,
  input  logic [31:0] ctl3,
  output route_t      rt
);
  logic       res_sel;
  logic [5:0] vt, st;
  logic       unused_bits;

  assign res_sel = ctl0[30];
  assign vt      = ctl0[20:15];
  assign st      = ctl3[12:7];

  always_comb begin
    rt           = '0;
    rt.v_cc      = (vt == IDX_RESERVED) && !res_sel;
    rt.v_out     = res_sel;
    rt.v_tmp     = (vt != IDX_RESERVED);
    rt.v_tmp_idx = vt;
    rt.s_tmp     = (st != IDX_RESERVED);
    rt.s_out     = (st == IDX_RESERVED) && !res_sel;
    rt.s_cc      = (st == IDX_RESERVED) && res_sel;
    rt.s_tmp_idx = st;
    rt.out_idx   = ctl3[6:2];
    rt.cc_sel    = ctl0[25];
    rt.sat       = ctl0[26];
    rt.cond_en   = ctl0[13];
    rt.code      = ctl0[12:10];
    rt.swz       = {ctl0[3:2], ctl0[5:4], ctl0[7:6], ctl0[9:8]};
    rt.vmask     = {ctl3[13], ctl3[14], ctl3[15], ctl3[16]};
    rt.smask     = {ctl3[17], ctl3[18], ctl3[19], ctl3[20]};
  end

  assign unused_bits = ^{ctl0[31], ctl0[29:27], ctl0[24:21], ctl0[14], ctl0[1:0],
                         ctl3[31:21], ctl3[1:0]};
endmodule

// File: rtl/cc_cond_eval.sv
`timescale 1ns/1ps
module cc_cond_eval
  import cc_wb_pkg::*;
#(
  parameter int NL = 4
)(
  input  logic [NL*LANE_W-1:0] cc_val,
  input  logic [2*NL-1:0]      swz,
  input  logic [2:0]           code,
  output logic [NL-1:0]        pass
);
  lane_t src [NL];

  for (genvar i = 0; i < NL; i++) begin : g_lane
    lane_t      pick;
    logic [2:0] cls;
    assign src[i] = cc_val[i*LANE_W +: LANE_W];
    assign pick   = src[swz[2*i +: 2]];
    assign cls    = fp_class(pick);
    assign pass[i] = (code == 3'b111) || ((cls & code) != 3'b000);
  end
endmodule

// File: rtl/cc_wb_router.sv
`timescale 1ns/1ps
module cc_wb_router
  import cc_wb_pkg::*;
#(
  parameter int NTMP = 32,
  parameter int NOUT = 16
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [31:0]               ctl0,
  input  logic [31:0]               ctl3,
  input  logic [LANES*LANE_W-1:0]   vec_data,
  input  logic [LANE_W-1:0]         sca_data,
  input  logic [$clog2(NTMP)-1:0]   tmp_raddr,
  output logic [LANES*LANE_W-1:0]   tmp_rdata,
  input  logic [$clog2(NOUT)-1:0]   out_raddr,
  output logic [LANES*LANE_W-1:0]   out_rdata,
  input  logic                      cc_raddr,
  output logic [LANES*LANE_W-1:0]   cc_rdata
);
  localparam int TW = $clog2(NTMP);
  localparam int OW = $clog2(NOUT);
  localparam int QW = LANES * LANE_W;
  localparam logic [5:0] TMP_LIM = 6'(NTMP);
  localparam logic [4:0] OUT_LIM = 5'(NOUT);

  route_t           rt;
  logic             fire;
  logic [QW-1:0]    tmp_q [NTMP];
  logic [QW-1:0]    out_q [NOUT];
  logic [QW-1:0]    cc_q  [NCC];
  logic [QW-1:0]    cc_src, vw, sw;
  logic [LANES-1:0] cond_pass, vmask_eff;
  logic             v_tmp_ok, v_out_ok, s_tmp_ok, s_out_ok;

  assign in_ready = 1'b1;
  assign fire     = in_valid && in_ready;

  cc_route_dec u_dec (.ctl0(ctl0), .ctl3(ctl3), .rt(rt));

  assign cc_src = cc_q[rt.cc_sel];

  cc_cond_eval #(.NL(LANES)) u_cond (
    .cc_val(cc_src), .swz(rt.swz), .code(rt.code), .pass(cond_pass)
  );

  assign vmask_eff = rt.vmask & (rt.cond_en ? cond_pass : {LANES{1'b1}});
  assign v_tmp_ok  = rt.v_tmp && (rt.v_tmp_idx < TMP_LIM);
  assign v_out_ok  = rt.v_out && (rt.out_idx < OUT_LIM);
  assign s_tmp_ok  = rt.s_tmp && (rt.s_tmp_idx < TMP_LIM);
  assign s_out_ok  = rt.s_out && (rt.out_idx < OUT_LIM);

  for (genvar l = 0; l < LANES; l++) begin : g_data
    assign vw[l*LANE_W +: LANE_W] = rt.sat ? sat_lane(vec_data[l*LANE_W +: LANE_W])
                                           : vec_data[l*LANE_W +: LANE_W];
    assign sw[l*LANE_W +: LANE_W] = rt.sat ? sat_lane(sca_data) : sca_data;

    assert_sat_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rt.sat |-> (!vw[l*LANE_W+31] && (vw[l*LANE_W +: LANE_W] <= FP_ONE)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTMP; i++) tmp_q[i] <= '0;
      for (int i = 0; i < NOUT; i++) out_q[i] <= '0;
      for (int i = 0; i < NCC; i++)  cc_q[i]  <= '0;
    end else if (fire) begin
      for (int l = 0; l < LANES; l++) begin
        // vector path first, scalar after so it wins on overlap
        if (rt.v_cc && vmask_eff[l])
          cc_q[rt.cc_sel][l*LANE_W +: LANE_W] <= vw[l*LANE_W +: LANE_W];
        if (v_out_ok && vmask_eff[l])
          out_q[rt.out_idx[OW-1:0]][l*LANE_W +: LANE_W] <= vw[l*LANE_W +: LANE_W];
        if (v_tmp_ok && vmask_eff[l])
          tmp_q[rt.v_tmp_idx[TW-1:0]][l*LANE_W +: LANE_W] <= vw[l*LANE_W +: LANE_W];
        if (rt.s_cc && rt.smask[l])
          cc_q[rt.cc_sel][l*LANE_W +: LANE_W] <= sw[l*LANE_W +: LANE_W];
        if (s_out_ok && rt.smask[l])
          out_q[rt.out_idx[OW-1:0]][l*LANE_W +: LANE_W] <= sw[l*LANE_W +: LANE_W];
        if (s_tmp_ok && rt.smask[l])
          tmp_q[rt.s_tmp_idx[TW-1:0]][l*LANE_W +: LANE_W] <= sw[l*LANE_W +: LANE_W];
      end
    end
  end

  assign tmp_rdata = tmp_q[tmp_raddr];
  assign out_rdata = out_q[out_raddr];
  assign cc_rdata  = cc_q[cc_raddr];

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(cc_q[0]) && $stable(cc_q[1]) && $stable(out_q[0]) && $stable(tmp_q[0])));

  assert_code_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rt.cond_en && rt.code == 3'd0) |-> (vmask_eff == '0));

  assert_code_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rt.cond_en && rt.code == 3'd7) |-> (vmask_eff == rt.vmask));

  assert_cc_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rt.v_cc |-> (!v_out_ok && !v_tmp_ok));

  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rt.cond_en |-> (vmask_eff == rt.vmask));

  assert_scalar_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && v_tmp_ok && s_tmp_ok && (rt.v_tmp_idx == rt.s_tmp_idx) && rt.smask[0] && vmask_eff[0])
    |=> (tmp_q[$past(rt.s_tmp_idx[TW-1:0])][LANE_W-1:0] == $past(sw[LANE_W-1:0])));
endmodule

// File: tb/cc_wb_router_bench.sv
`timescale 1ns/1ps
module cc_wb_router_bench;
  localparam logic [31:0] P1 = 32'h3F80_0000, M1 = 32'hBF80_0000, ZP = 32'h0,
                          ZN = 32'h8000_0000, QN = 32'h7FC0_0000, HF = 32'h3F00_0000,
                          TWO = 32'h4000_0000, MH = 32'hBF00_0000, INF = 32'h7F80_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  ctl0 = '0, ctl3 = '0;
  logic [127:0] vec_data = '0;
  logic [31:0]  sca_data = '0;
  logic [4:0]   tmp_raddr = '0;
  logic [3:0]   out_raddr = '0;
  logic         cc_raddr = 1'b0;
  logic [127:0] tmp_rdata, out_rdata, cc_rdata;

  int errs = 0;
  int checks = 0;

  logic [31:0] mt [32][4];
  logic [31:0] mo [16][4];
  logic [31:0] mc [2][4];

  always #2.5 clk = ~clk;

  cc_wb_router u_cc_wb_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ctl0(ctl0), .ctl3(ctl3), .vec_data(vec_data), .sca_data(sca_data),
    .tmp_raddr(tmp_raddr), .tmp_rdata(tmp_rdata), .out_raddr(out_raddr),
    .out_rdata(out_rdata), .cc_raddr(cc_raddr), .cc_rdata(cc_rdata)
  );

  function automatic logic [31:0] mk0(int vt, bit rs, bit sat, bit sel, bit en, int code,
                                      int sx, int sy, int sz, int sw);
    logic [31:0] w = '0;
    w[20:15] = 6'(vt); w[30] = rs; w[26] = sat; w[25] = sel; w[13] = en;
    w[12:10] = 3'(code); w[9:8] = 2'(sx); w[7:6] = 2'(sy); w[5:4] = 2'(sz); w[3:2] = 2'(sw);
    return w;
  endfunction

  // masks given as {w,z,y,x}
  function automatic logic [31:0] mk3(int dst, int st, logic [3:0] vm, logic [3:0] sm);
    logic [31:0] w = '0;
    w[6:2] = 5'(dst); w[12:7] = 6'(st);
    w[16] = vm[0]; w[15] = vm[1]; w[14] = vm[2]; w[13] = vm[3];
    w[20] = sm[0]; w[19] = sm[1]; w[18] = sm[2]; w[17] = sm[3];
    return w;
  endfunction

  function automatic bit is_nan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic logic [31:0] clamp01(logic [31:0] v);
    if (is_nan(v) || v[31]) return 32'h0;
    if (v >= P1) return P1;
    return v;
  endfunction

  task automatic model_apply();
    bit rs = ctl0[30], sel = ctl0[25], en = ctl0[13], sat = ctl0[26];
    int code = int'(ctl0[12:10]);
    int vt = int'(ctl0[20:15]), st = int'(ctl3[12:7]), dst = int'(ctl3[6:2]);
    bit vm [4];
    bit sm [4];
    logic [31:0] vv [4];
    logic [31:0] sv;
    for (int i = 0; i < 4; i++) begin
      int s;
      logic [31:0] c;
      bit ok;
      s = (i == 0) ? int'(ctl0[9:8]) : (i == 1) ? int'(ctl0[7:6]) :
          (i == 2) ? int'(ctl0[5:4]) : int'(ctl0[3:2]);
      c = mc[sel][s];
      ok = (code == 7) ||
           (code[0] && !is_nan(c) && c[30:0] != 0 && c[31]) ||
           (code[1] && c[30:0] == 0) ||
           (code[2] && !is_nan(c) && c[30:0] != 0 && !c[31]);
      vm[i] = ctl3[16-i] && (!en || ok);
      sm[i] = ctl3[20-i];
      vv[i] = sat ? clamp01(vec_data[32*i +: 32]) : vec_data[32*i +: 32];
    end
    sv = sat ? clamp01(sca_data) : sca_data;
    for (int i = 0; i < 4; i++) begin
      if (vm[i]) begin
        if (vt == 63 && !rs) mc[sel][i] = vv[i];
        else begin
          if (rs && dst < 16) mo[dst][i] = vv[i];
          if (vt < 32) mt[vt][i] = vv[i];
        end
      end
      if (sm[i]) begin
        if (st != 63) begin
          if (st < 32) mt[st][i] = sv;
        end else if (!rs) begin
          if (dst < 16) mo[dst][i] = sv;
        end else mc[sel][i] = sv;
      end
    end
  endtask

  task automatic check_q(string tag, string what, int idx, logic [127:0] got,
                         logic [31:0] e3, logic [31:0] e2, logic [31:0] e1, logic [31:0] e0);
    checks++;
    if (got !== {e3, e2, e1, e0}) begin
      errs++;
      $display("FAIL %s %s[%0d] actual=%h expected=%h", tag, what, idx, got, {e3, e2, e1, e0});
    end
  endtask

  task automatic compare_all(string tag);
    for (int t = 0; t < 32; t++) begin
      tmp_raddr = 5'(t); #0.02;
      check_q(tag, "tmp", t, tmp_rdata, mt[t][3], mt[t][2], mt[t][1], mt[t][0]);
    end
    for (int t = 0; t < 16; t++) begin
      out_raddr = 4'(t); #0.02;
      check_q(tag, "out", t, out_rdata, mo[t][3], mo[t][2], mo[t][1], mo[t][0]);
    end
    for (int t = 0; t < 2; t++) begin
      cc_raddr = 1'(t); #0.02;
      check_q(tag, "cc", t, cc_rdata, mc[t][3], mc[t][2], mc[t][1], mc[t][0]);
    end
  endtask

  task automatic step(bit v, logic [31:0] a0, logic [31:0] a3, logic [127:0] vd,
                      logic [31:0] sd, string tag);
    @(negedge clk);
    in_valid = v; ctl0 = a0; ctl3 = a3; vec_data = vd; sca_data = sd;
    @(posedge clk);
    if (v) model_apply();
    #0.1;
    checks++;
    if (in_ready !== 1'b1) begin
      errs++;
      $display("FAIL R1 in_ready actual=%b expected=1", in_ready);
    end
    compare_all(tag);
  endtask

  function automatic logic [31:0] pick(int r);
    case (r % 10)
      0: return P1;  1: return M1;  2: return ZP;  3: return ZN;  4: return QN;
      5: return HF;  6: return TWO; 7: return MH;  8: return INF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) for (int l = 0; l < 4; l++) mt[i][l] = '0;
    for (int i = 0; i < 16; i++) for (int l = 0; l < 4; l++) mo[i][l] = '0;
    for (int i = 0; i < 2; i++)  for (int l = 0; l < 4; l++) mc[i][l] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare_all("R2");

    // vector to temp 5 and output 3
    step(1, mk0(5, 1, 0, 0, 0, 0, 0, 1, 2, 3), mk3(3, 63, 4'b1111, 4'b0000),
         {TWO, HF, M1, P1}, ZP, "R7");
    // vector to condition register 0: x=-1 y=0 z=+1 w=NaN
    step(1, mk0(63, 0, 0, 0, 0, 0, 0, 1, 2, 3), mk3(0, 63, 4'b1111, 4'b0000),
         {QN, P1, ZP, M1}, ZP, "R6");
    // condition codes, identity swizzle
    step(1, mk0(7, 0, 0, 0, 1, 1, 0, 1, 2, 3), mk3(0, 63, 4'b1111, 0), {4{TWO}}, ZP, "R3");
    step(1, mk0(8, 0, 0, 0, 1, 2, 0, 1, 2, 3), mk3(0, 63, 4'b1111, 0), {4{TWO}}, ZP, "R3");
    step(1, mk0(9, 0, 0, 0, 1, 4, 0, 1, 2, 3), mk3(0, 63, 4'b1111, 0), {4{TWO}}, ZP, "R3");
    step(1, mk0(10, 0, 0, 0, 1, 0, 0, 1, 2, 3), mk3(0, 63, 4'b1111, 0), {4{TWO}}, ZP, "R3");
    step(1, mk0(11, 0, 0, 0, 1, 7, 0, 1, 2, 3), mk3(0, 63, 4'b1111, 0), {4{TWO}}, ZP, "R3");
    step(1, mk0(12, 0, 0, 0, 1, 6, 0, 1, 2, 3), mk3(0, 63, 4'b1111, 0), {4{TWO}}, ZP, "R3");
    // reversed swizzle and other register
    step(1, mk0(13, 0, 0, 0, 1, 1, 3, 2, 1, 0), mk3(0, 63, 4'b1111, 0), {4{TWO}}, ZP, "R4");
    step(1, mk0(14, 0, 0, 1, 1, 2, 0, 1, 2, 3), mk3(0, 63, 4'b1111, 0), {4{TWO}}, ZP, "R4");
    // gating off: code 0 ignored, raw mask
    step(1, mk0(15, 0, 0, 0, 0, 0, 0, 1, 2, 3), mk3(0, 63, 4'b1010, 0), {4{TWO}}, ZP, "R5");
    // scalar destinations
    step(1, mk0(63, 0, 0, 0, 0, 0, 0, 1, 2, 3), mk3(0, 16, 4'b0000, 4'b0110), {4{TWO}}, HF, "R8");
    step(1, mk0(63, 0, 0, 0, 0, 0, 0, 1, 2, 3), mk3(12, 63, 4'b0000, 4'b1111), {4{TWO}}, M1, "R8");
    step(1, mk0(63, 1, 0, 1, 0, 0, 0, 1, 2, 3), mk3(20, 63, 4'b1111, 4'b1001), {4{TWO}}, HF, "R8");
    // saturation
    step(1, mk0(17, 0, 1, 0, 0, 0, 0, 1, 2, 3), mk3(0, 18, 4'b1111, 4'b1111),
         {INF, QN, TWO, MH}, ZN, "R9");
    step(1, mk0(20, 0, 1, 0, 0, 0, 0, 1, 2, 3), mk3(0, 21, 4'b1111, 4'b1111),
         {HF, P1, 32'h3F80_0001, ZN}, 32'hFFC0_0000, "R9");
    // same temp from both paths
    step(1, mk0(19, 0, 0, 0, 0, 0, 0, 1, 2, 3), mk3(0, 19, 4'b1111, 4'b0011),
         {4{TWO}}, HF, "R10");
    // out-of-range indices write nothing
    step(1, mk0(40, 1, 0, 0, 0, 0, 0, 1, 2, 3), mk3(20, 50, 4'b1111, 4'b1111),
         {4{M1}}, M1, "R7");
    // idle cycle with write-everything fields
    step(0, mk0(1, 1, 0, 0, 0, 0, 0, 1, 2, 3), mk3(1, 2, 4'b1111, 4'b1111),
         {4{INF}}, INF, "R1");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a0, a3;
      a0 = $urandom(); a3 = $urandom();
      if (n % 4 == 0) a0[20:15] = 6'd63;
      if (n % 5 == 0) a3[12:7] = 6'd63;
      step(($urandom() % 5) != 0, a0, a3,
           {pick($urandom()), pick($urandom()), pick($urandom()), pick($urandom())},
           pick($urandom()), "R11");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule